// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock static memory with a registered front end and a one-stage read pipeline. Every synchronous control and data input is captured on the rising clock edge. The access that those captured values describe is carried out on the next edge. That edge either stores write data into the array or loads read data into an output register. A burst opens when one of two address strobes is asserted: one strobe comes from a processor, the other from a memory controller. The burst then moves through up to four words under an internal two-bit counter. A static pin picks the visiting order: linear wrap or interleaved.

Each data word is split into byte lanes of nine bits: eight data bits plus one parity bit. Each lane has its own active-low write enable. A global write input overrides the lane enables and stores the whole word. Depth expansion uses three select inputs. The output bus is modelled as a data vector together with a drive flag, which a pad ring turns into a three-state bus. An asynchronous output enable gates the drive flag. A deselect that follows a read releases the bus one edge after it is captured.

Top module: `sync_burst_sram`

## Requirements
- R1: The block is selected only when `sel_ni`=0, `sel_hi_i`=1 and `sel_lo_ni`=0 at the starting edge. A strobe-started cycle that is not selected neither writes the array nor drives the bus.
- R2: A controller strobe (`strobe_ctl_ni`=0) loads `addr_i` and resets the burst counter. It reads, or writes when the write controls are active. Read data for a cycle captured on edge N appear on `dq_o` with `dq_drv_o`=1 after edge N+1, and not before.
- R3: A processor strobe (`strobe_cpu_ni`=0) always starts a read and ignores the write controls on that cycle. It has priority when both strobes are low. The next cycle, with `advance_ni`=1 and write controls active, writes to the loaded address.
- R4: The processor strobe is ignored while `sel_ni`=1. Such a cycle continues the open burst.
- R5: On a cycle without a start, the counter advances by one only when `advance_ni`=0. Otherwise the same address is accessed again.
- R6: With `burst_ilv_i`=0, the low two address bits are the start bits plus the count, modulo 4. The upper bits stay fixed.
- R7: With `burst_ilv_i`=1, the low two address bits are the start bits XOR the count. A start of 1 gives the order 1,0,3,2.
- R8: `bw_ni[l]`=0 writes only lane l, which is `dq`/`data_i` bits [9l+8:9l]. Bit 9l+8 is that lane's parity. The other lanes keep their old contents.
- R9: `gw_ni`=0 writes every lane, whatever `bw_ni` holds.
- R10: `dq_drv_o` is 1 only while `oe_ni`=0. It follows `oe_ni` without a clock edge.
- R11: A deselect captured on the edge right after a read's capture edge clears `dq_drv_o` after the following edge.
- R12: While reset is asserted, and after it is released, the bus is not driven and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | 9*LANES | Write data, lane l at bits [9l+8:9l], parity at bit 9l+8 |
| sel_ni | input | 1 | Primary select, active low |
| sel_hi_i | input | 1 | Expansion select, active high |
| sel_lo_ni | input | 1 | Expansion select, active low |
| strobe_cpu_ni | input | 1 | Processor address strobe, active low |
| strobe_ctl_ni | input | 1 | Controller address strobe, active low |
| advance_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bw_ni | input | LANES | Per-lane write enables, active low |
| burst_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | 9*LANES | Read data, zero when not driven |
| dq_drv_o | output | 1 | Bus drive flag |

## Verification
The bench runs linear bursts that wrap from a start near the top of a four-word block, and interleaved bursts from an odd start. A counter with the wrong order or a missing wrap returns data from the wrong word. It holds the advance input high in the middle of a burst, so a counter that steps regardless repeats no word and skips ahead. A processor-strobe cycle carries active write controls, and another cycle has both strobes low. A design that honours writes on those cycles corrupts the word that is read back later. Partial writes check that the untouched lane, parity bit included, survives. Deselect-after-read and toggles of the output enable catch a bus that is held a cycle too long or that waits for a clock edge.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANE_W = 9;

  typedef struct packed {
    logic sel_n;
    logic sel_hi;
    logic sel_lo_n;
    logic cpu_n;
    logic ctl_n;
    logic adv_n;
    logic gw_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b1, sel_hi: 1'b0, sel_lo_n: 1'b1,
                                  cpu_n: 1'b1, ctl_n: 1'b1, adv_n: 1'b1, gw_n: 1'b1};

  function automatic logic [1:0] burst_low(input logic [1:0] base, input logic [1:0] cnt,
                                           input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  ctrl_t                     ctrl_i,
  input  logic [LANES-1:0]          bw_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   data_i,
  output ctrl_t                     ctrl_o,
  output logic [LANES-1:0]          bw_no,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [LANES*LANE_W-1:0]   data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_IDLE;
      bw_no  <= '1;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      ctrl_o <= ctrl_i;
      bw_no  <= bw_ni;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/sbs_burst_ctl.sv
module sbs_burst_ctl import sbs_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_valid_o,
  output logic              acc_wr_o
);
  logic              sel, start_p, start_c, start;
  logic [1:0]        cnt_q, cnt_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              act_q, act_d, wr;

  assign sel     = !ctrl_i.sel_n && ctrl_i.sel_hi && !ctrl_i.sel_lo_n;
  assign start_p = !ctrl_i.cpu_n && !ctrl_i.sel_n;   // gated by primary select
  assign start_c = !ctrl_i.ctl_n && !start_p;
  assign start   = start_p || start_c;

  always_comb begin
    if (start) begin
      cnt_d  = '0;
      base_d = addr_i;
      act_d  = sel;
      wr     = start_c && wr_req_i;  // processor start is always a read
    end else begin
      cnt_d  = cnt_q + {1'b0, !ctrl_i.adv_n};
      base_d = base_q;
      act_d  = act_q;
      wr     = wr_req_i;
    end
  end

  assign acc_addr_o  = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], cnt_d, ilv_i)};
  assign acc_valid_o = act_d;
  assign acc_wr_o    = act_d && wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      base_q <= base_d;
      act_q  <= act_d;
    end
  end

  AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start && ctrl_i.adv_n) |=> $stable(cnt_q)) else $error("counter moved"); // R5
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == 2'd0 && base_q == $past(addr_i))) else $error("start load"); // R2
  AST_CPU_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |-> !acc_wr_o) else $error("cpu start wrote"); // R3
endmodule

// File: rtl/sbs_array.sv
module sbs_array import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (re_i) q <= mem[addr_i];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = q;

    AST_LANE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && lane_we_i[l]) |=> mem[$past(addr_i)] == $past(wdata_i[l*LANE_W +: LANE_W]))
      else $error("lane store"); // R8
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbs_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    sel_ni,
  input  logic                    sel_hi_i,
  input  logic                    sel_lo_ni,
  input  logic                    strobe_cpu_ni,
  input  logic                    strobe_ctl_ni,
  input  logic                    advance_ni,
  input  logic                    gw_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    burst_ilv_i,
  input  logic                    oe_ni,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_drv_o
);
  localparam int DATA_W = LANES * LANE_W;

  ctrl_t              ctrl_in, r_ctrl;
  logic [LANES-1:0]   r_bw_n, lane_we;
  logic [ADDR_W-1:0]  r_addr, acc_addr;
  logic [DATA_W-1:0]  r_data, rdata;
  logic               wr_req, acc_valid, acc_wr, drv_q;

  assign ctrl_in = '{sel_n: sel_ni, sel_hi: sel_hi_i, sel_lo_n: sel_lo_ni,
                     cpu_n: strobe_cpu_ni, ctl_n: strobe_ctl_ni,
                     adv_n: advance_ni, gw_n: gw_ni};

  sbs_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in_reg (
    .clk_i, .rst_ni, .ctrl_i(ctrl_in), .bw_ni, .addr_i, .data_i,
    .ctrl_o(r_ctrl), .bw_no(r_bw_n), .addr_o(r_addr), .data_o(r_data)
  );

  assign wr_req  = !r_ctrl.gw_n || !(&r_bw_n);
  assign lane_we = r_ctrl.gw_n ? ~r_bw_n : '1;   // global write overrides lanes

  sbs_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i, .rst_ni, .ctrl_i(r_ctrl), .wr_req_i(wr_req), .addr_i(r_addr),
    .ilv_i(burst_ilv_i), .acc_addr_o(acc_addr), .acc_valid_o(acc_valid), .acc_wr_o(acc_wr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk_i, .rst_ni, .we_i(acc_wr), .re_i(acc_valid && !acc_wr), .addr_i(acc_addr),
    .lane_we_i(lane_we), .wdata_i(r_data), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= acc_valid && !acc_wr;
  end

  assign dq_drv_o = drv_q && !oe_ni;
  assign dq_o     = dq_drv_o ? rdata : '0;

  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_drv_o) else $error("drive without oe"); // R10
  AST_DESEL_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid |=> !dq_drv_o) else $error("bus held after deselect"); // R11
  AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |=> !dq_drv_o) else $error("bus driven on write"); // R1
endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic          sel_n = 1'b1, sel_hi = 1'b0, sel_lo_n = 1'b1;
  logic          cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1, gw_n = 1'b1;
  logic [1:0]    bw_n = 2'b11;
  logic          ilv = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] dq;
  logic          drv;

  int vectors = 0, miscmp = 0;
  logic [DW-1:0] ref_mem [64];

  always #10 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .sel_ni(sel_n), .sel_hi_i(sel_hi), .sel_lo_ni(sel_lo_n),
    .strobe_cpu_ni(cpu_n), .strobe_ctl_ni(ctl_n), .advance_ni(adv_n),
    .gw_ni(gw_n), .bw_ni(bw_n), .burst_ilv_i(ilv), .oe_ni(oe_n),
    .dq_o(dq), .dq_drv_o(drv)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 2731) ^ 18'h15A5A);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp_drv, input logic [DW-1:0] exp_q);
    vectors++;
    if (drv !== exp_drv || (exp_drv && dq !== exp_q)) begin
      miscmp++;
      $display("FAIL %s: drv=%0b q=%h expected drv=%0b q=%h", tag, drv, dq, exp_drv, exp_q);
    end
  endtask

  task automatic selected();
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
  endtask

  task automatic no_write();
    gw_n = 1'b1; bw_n = 2'b11;
  endtask

  task automatic deselect();
    sel_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0;
    cpu_n = 1'b1; ctl_n = 1'b0; adv_n = 1'b1; no_write();
  endtask

  task automatic ctl_start(input logic [AW-1:0] a, input logic g, input logic [1:0] b,
                           input logic [DW-1:0] d);
    selected(); cpu_n = 1'b1; ctl_n = 1'b0; adv_n = 1'b1;
    addr = a; gw_n = g; bw_n = b; data = d;
  endtask

  task automatic settle();
    deselect(); tick(); tick();
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R12 in reset", 1'b0, '0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R12 after reset", 1'b0, '0);
  endtask

  task automatic fill();
    for (int a = 0; a < 64; a++) begin
      ctl_start(AW'(a), 1'b0, 2'b11, pat(a));
      ref_mem[a] = pat(a);
      tick();
    end
    settle();
  endtask

  task automatic single_read(input logic [AW-1:0] a, input string tag);
    settle();
    ctl_start(a, 1'b1, 2'b11, '0);
    tick();
    chk({tag, " R2 latency"}, 1'b0, '0);
    deselect();
    tick();
    chk({tag, " R2 data"}, 1'b1, ref_mem[a]);
    tick();
    chk({tag, " R11 float"}, 1'b0, '0);
  endtask

  task automatic run_burst(input logic mode, input logic [AW-1:0] a, input logic use_cpu,
                           input logic [3:0] adv, input string tag);
    logic [1:0]    c;
    logic [AW-1:0] prev;
    settle();
    ilv = mode;
    selected(); no_write(); addr = a; adv_n = 1'b1;
    cpu_n = !use_cpu; ctl_n = use_cpu;
    tick();
    c = 2'd0; prev = a;
    for (int i = 0; i < 4; i++) begin
      cpu_n = 1'b1; ctl_n = 1'b1; adv_n = !adv[i]; addr = '0;
      if (adv[i]) c = c + 2'd1;
      tick();
      chk(tag, 1'b1, ref_mem[prev]);
      prev = {a[AW-1:2], mode ? (a[1:0] ^ c) : (a[1:0] + c)};
    end
    deselect();
    tick();
    chk(tag, 1'b1, ref_mem[prev]);
    tick();
    chk("R11 deselect after burst read", 1'b0, '0);
    ilv = 1'b0;
  endtask

  task automatic test_cpu_gated();
    settle();
    ctl_start(6'h20, 1'b1, 2'b11, '0);
    tick();
    sel_n = 1'b1; cpu_n = 1'b0; ctl_n = 1'b1; adv_n = 1'b0; addr = 6'h33;
    tick();
    chk("R4 burst start word", 1'b1, ref_mem[6'h20]);
    deselect();
    tick();
    chk("R4 cpu strobe ignored, burst continued", 1'b1, ref_mem[6'h21]);
    tick();
  endtask

  task automatic test_cpu_write();
    settle();
    selected(); cpu_n = 1'b0; ctl_n = 1'b1; adv_n = 1'b1;
    addr = 6'h10; gw_n = 1'b0; data = 18'h0AAAA;
    tick();
    cpu_n = 1'b1; adv_n = 1'b1; gw_n = 1'b0; data = 18'h35555; addr = '0;
    tick();
    chk("R3 cpu start reads, write ignored", 1'b1, ref_mem[6'h10]);
    ref_mem[6'h10] = 18'h35555;
    deselect();
    tick();
    chk("R3 write cycle not driven", 1'b0, '0);
    settle();
    selected(); cpu_n = 1'b0; ctl_n = 1'b0; addr = 6'h11; gw_n = 1'b0; data = 18'h01234;
    tick();
    deselect();
    tick();
    chk("R3 both strobes: processor wins, read", 1'b1, ref_mem[6'h11]);
    single_read(6'h10, "R3 next-cycle write landed");
    single_read(6'h11, "R3 priority write suppressed");
  endtask

  task automatic test_lanes();
    logic [DW-1:0] d;
    d = 18'h2C3B7;
    settle();
    ctl_start(6'h05, 1'b1, 2'b10, d); tick(); settle();
    ref_mem[6'h05] = {ref_mem[6'h05][17:9], d[8:0]};
    single_read(6'h05, "R8 lane0 only");
    ctl_start(6'h06, 1'b1, 2'b01, d); tick(); settle();
    ref_mem[6'h06] = {d[17:9], ref_mem[6'h06][8:0]};
    single_read(6'h06, "R8 lane1 with parity only");
    ctl_start(6'h07, 1'b0, 2'b11, 18'h1F0E1); tick(); settle();
    ref_mem[6'h07] = 18'h1F0E1;
    single_read(6'h07, "R9 global write all lanes");
    ctl_start(6'h09, 1'b0, 2'b10, 18'h0BEEF); tick(); settle();
    ref_mem[6'h09] = 18'h0BEEF;
    single_read(6'h09, "R9 global overrides lane enables");
  endtask

  task automatic test_select();
    settle();
    ctl_start(6'h08, 1'b0, 2'b11, 18'h3FFFF); sel_hi = 1'b0; tick(); settle();
    single_read(6'h08, "R1 write with sel_hi low ignored");
    ctl_start(6'h0A, 1'b0, 2'b11, 18'h3FFFF); sel_lo_n = 1'b1; tick(); settle();
    single_read(6'h0A, "R1 write with sel_lo high ignored");
    ctl_start(6'h0B, 1'b1, 2'b11, '0); sel_lo_n = 1'b1;
    tick(); deselect(); tick();
    chk("R1 unselected read not driven", 1'b0, '0);
  endtask

  task automatic test_oe();
    settle();
    ctl_start(6'h0C, 1'b1, 2'b11, '0);
    tick();
    deselect();
    tick();
    #2 oe_n = 1'b1;
    #1 chk("R10 oe high floats", 1'b0, '0);
    #1 oe_n = 1'b0;
    #1 chk("R10 oe low drives", 1'b1, ref_mem[6'h0C]);
    tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    test_reset();
    fill();
    single_read(6'h2A, "R2 controller read");
    run_burst(1'b0, 6'h0E, 1'b1, 4'b1111, "R6 linear wrap");
    run_burst(1'b0, 6'h15, 1'b0, 4'b1101, "R5 linear hold mid-burst");
    run_burst(1'b1, 6'h31, 1'b1, 4'b1111, "R7 interleaved 1,0,3,2");
    run_burst(1'b1, 6'h1A, 1'b0, 4'b1011, "R7 interleaved with hold R5");
    test_cpu_gated();
    test_cpu_write();
    test_lanes();
    test_select();
    test_oe();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule